// File: doc/BRIEF.md
# Divider Configuration Loader with Parallel and Serial Paths

This block keeps the configuration word for a clock synthesizer's divider chain: a 9-bit feedback multiplier, a 2-bit output divider code and a 3-bit test-select code. The word can arrive in two ways. Parallel pins give the multiplier and output divider directly. A three-wire serial port (clock, data, strobe) shifts in a full word that also carries the test code. Both paths feed one set of configuration registers.

The pin-level latches are level sensitive. Here a fast system clock samples every control input, and those inputs are taken as already synchronised. The parallel hold input is the parallel path's latch control. While it is low the registers follow the pins and the test code is held at zero. On its rising edge the last pin value stays in the registers. While the hold input is high, the serial strobe makes the registers follow the serial word, and the falling edge of the strobe freezes that word. The usual flow is a parallel load after power-up, followed later by serial retuning. The top bit of the serial shift register is brought out so that a test multiplexer can show it.

Top module: `cfg_if_top`

## Requirements
- R1: While `rst` is high, every configuration output and the shift register are cleared to zero. At the next sampled clock the outputs read multiplier 0, divider 0, test 0 and tail 0.
- R2: The shift register is 14 bits wide. It moves one place toward its top bit, taking `scfg_din` into bit 0, exactly once for each low-to-high change of `scfg_clk`. Holding `scfg_clk` high for several system clocks causes no further shifts.
- R3: After 14 serial bits the word decodes as follows. The first three bits sent are the test code, MSB first. The next two are the divider code, MSB first. The last nine are the multiplier, MSB first, so the final bit sent is multiplier bit 0.
- R4: While `pcfg_hold` is high and `scfg_strobe` is high, the outputs take the decoded shift word one system clock later. When `scfg_strobe` falls, the outputs keep that word even while more serial bits are shifted in.
- R5: While `pcfg_hold` is low, `mult_o` and `odiv_o` follow `pin_mult` and `pin_odiv` with one system clock of delay. When `pcfg_hold` rises, they keep the value sampled in the last low cycle.
- R6: While `pcfg_hold` is low, `tsel_o` is 000 one system clock later. The pins have no path to the test code.
- R7: When `pcfg_hold` is low, `scfg_strobe` has no effect. The parallel path takes priority for all fields.
- R8: A transfer does not clear the shift register. A later strobe with no new serial bits applies the same word again.
- R9: `ser_tail_o` always shows bit 13 of the shift register (the test-code MSB position), whatever the state of `pcfg_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scfg_clk | input | 1 | Serial shift clock, sampled level |
| scfg_din | input | 1 | Serial data bit |
| scfg_strobe | input | 1 | Serial latch control, transparent when high |
| pcfg_hold | input | 1 | Parallel latch control, transparent when low |
| pin_mult | input | 9 | Parallel multiplier value |
| pin_odiv | input | 2 | Parallel output divider code |
| mult_o | output | 9 | Active multiplier value |
| odiv_o | output | 2 | Active output divider code |
| tsel_o | output | 3 | Active test-select code |
| ser_tail_o | output | 1 | Top bit of the serial shift register |

## Verification
Words with asymmetric bit patterns in each field are sent, so a swapped field order or a reversed bit order inside a field gives a visibly wrong multiplier, divider or test code. Serial clocks that stay high for several system clocks are used to tell a level-triggered shift from an edge-triggered one. The parallel pins are changed during the transparent phase and at the very cycle the hold input rises, which shows both the follow and the capture timing. Strobes are issued with the parallel hold low, and again with no new serial bits, to separate parallel priority from serial reapplication.

// File: rtl/cfg_if_pkg.sv
package cfg_if_pkg;
  localparam int DEF_MULT_W = 9;
  localparam int DEF_ODIV_W = 2;
  localparam int DEF_TSEL_W = 3;

  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_PINS  = 2'd1,
    SRC_SHIFT = 2'd2
  } cfg_src_e;

  // Parallel path wins whenever its latch is open.
  function automatic cfg_src_e pick_src(input logic par_hold, input logic ser_strobe);
    if (!par_hold)
      return SRC_PINS;
    else if (ser_strobe)
      return SRC_SHIFT;
    else
      return SRC_KEEP;
  endfunction
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = lvl & ~lvl_q;
    end else begin : g_fall
      assign edge_o = ~lvl & lvl_q;
    end
  endgenerate

  // R2: a pulse never lasts two cycles for a held level
  p_single_edge_r2: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word_o,
  output logic             tail_o
);
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (shift_en)
      word_q <= {word_q[WIDTH-2:0], din};
  end

  assign word_o = word_q;
  assign tail_o = word_q[WIDTH-1];

  // R2: one place per enable, new bit at the bottom
  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word_o == {$past(word_o[WIDTH-2:0]), $past(din)}));

  // R8: contents kept whenever no shift is requested
  p_shift_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word_o));
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_if_pkg::*;
#(
  parameter int MULT_W = DEF_MULT_W,
  parameter int ODIV_W = DEF_ODIV_W,
  parameter int TSEL_W = DEF_TSEL_W,
  localparam int WORD_W = MULT_W + ODIV_W + TSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_hold,
  input  logic              ser_strobe,
  input  logic [MULT_W-1:0] pin_mult,
  input  logic [ODIV_W-1:0] pin_odiv,
  input  logic [WORD_W-1:0] shift_word,
  output logic [MULT_W-1:0] mult_o,
  output logic [ODIV_W-1:0] odiv_o,
  output logic [TSEL_W-1:0] tsel_o
);
  logic [MULT_W-1:0] sh_mult;
  logic [ODIV_W-1:0] sh_odiv;
  logic [TSEL_W-1:0] sh_tsel;
  cfg_src_e          src;

  // Stream order: test field first, multiplier last.
  assign sh_tsel = shift_word[WORD_W-1 -: TSEL_W];
  assign sh_odiv = shift_word[MULT_W+ODIV_W-1 -: ODIV_W];
  assign sh_mult = shift_word[MULT_W-1:0];
  assign src     = pick_src(par_hold, ser_strobe);

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_o <= '0;
      odiv_o <= '0;
      tsel_o <= '0;
    end else begin
      unique case (src)
        SRC_PINS: begin
          mult_o <= pin_mult;
          odiv_o <= pin_odiv;
          tsel_o <= '0;
        end
        SRC_SHIFT: begin
          mult_o <= sh_mult;
          odiv_o <= sh_odiv;
          tsel_o <= sh_tsel;
        end
        default: ;
      endcase
    end
  end

  // R6: open parallel latch clears the test code
  p_tsel_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !par_hold |=> (tsel_o == '0));

  // R5 / R7: open parallel latch tracks the pins, strobe or not
  p_pin_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !par_hold |=> (mult_o == $past(pin_mult)) && (odiv_o == $past(pin_odiv)));

  // R4: serial transfer of the whole word
  p_ser_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    (par_hold && ser_strobe) |=> ({tsel_o, odiv_o, mult_o} == $past(shift_word)));

  // R4: both latches closed, configuration frozen
  p_closed_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (par_hold && !ser_strobe) |=> ($stable(mult_o) && $stable(odiv_o) && $stable(tsel_o)));
endmodule

// File: rtl/cfg_if_top.sv
module cfg_if_top
  import cfg_if_pkg::*;
#(
  parameter int MULT_W = DEF_MULT_W,
  parameter int ODIV_W = DEF_ODIV_W,
  parameter int TSEL_W = DEF_TSEL_W,
  localparam int WORD_W = MULT_W + ODIV_W + TSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scfg_clk,
  input  logic              scfg_din,
  input  logic              scfg_strobe,
  input  logic              pcfg_hold,
  input  logic [MULT_W-1:0] pin_mult,
  input  logic [ODIV_W-1:0] pin_odiv,
  output logic [MULT_W-1:0] mult_o,
  output logic [ODIV_W-1:0] odiv_o,
  output logic [TSEL_W-1:0] tsel_o,
  output logic              ser_tail_o
);
  logic              sclk_rise;
  logic [WORD_W-1:0] sh_word;

  cfg_edge_det #(.RISING(1'b1)) u_sclk_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl    (scfg_clk),
    .edge_o (sclk_rise)
  );

  cfg_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .din      (scfg_din),
    .word_o   (sh_word),
    .tail_o   (ser_tail_o)
  );

  cfg_latch #(
    .MULT_W (MULT_W),
    .ODIV_W (ODIV_W),
    .TSEL_W (TSEL_W)
  ) u_latch (
    .clk        (clk),
    .rst        (rst),
    .par_hold   (pcfg_hold),
    .ser_strobe (scfg_strobe),
    .pin_mult   (pin_mult),
    .pin_odiv   (pin_odiv),
    .shift_word (sh_word),
    .mult_o     (mult_o),
    .odiv_o     (odiv_o),
    .tsel_o     (tsel_o)
  );

  // R1: reset leaves everything cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (mult_o == '0) && (odiv_o == '0) && (tsel_o == '0) && !ser_tail_o);

  // R9: tail tracks the shift register's top bit
  p_tail_top_r9: assert property (@(posedge clk) disable iff (rst)
    ser_tail_o == sh_word[WORD_W-1]);
endmodule

// File: tb/tb_cfg_if_top.sv
module tb_cfg_if_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       scfg_clk, scfg_din, scfg_strobe, pcfg_hold;
  logic [8:0] pin_mult;
  logic [1:0] pin_odiv;
  logic [8:0] mult_o;
  logic [1:0] odiv_o;
  logic [2:0] tsel_o;
  logic       ser_tail_o;

  always #2 clk = ~clk;

  cfg_if_top dut (
    .clk(clk), .rst(rst), .scfg_clk(scfg_clk), .scfg_din(scfg_din),
    .scfg_strobe(scfg_strobe), .pcfg_hold(pcfg_hold),
    .pin_mult(pin_mult), .pin_odiv(pin_odiv),
    .mult_o(mult_o), .odiv_o(odiv_o), .tsel_o(tsel_o), .ser_tail_o(ser_tail_o)
  );

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       tail;
    string      tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  logic [13:0] sr_model = '0;
  logic [8:0]  e_m = '0;
  logic [1:0]  e_n = '0;
  logic [2:0]  e_t = '0;

  task automatic push(input string tag);
    exp_t e;
    e.m = e_m; e.n = e_n; e.t = e_t; e.tail = sr_model[13]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares in the middle of the low phase
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (mult_o !== e.m || odiv_o !== e.n || tsel_o !== e.t || ser_tail_o !== e.tail) begin
        n_bad++;
        $display("FAIL %s: got m=%h n=%b t=%b tail=%b exp m=%h n=%b t=%b tail=%b",
                 e.tag, mult_o, odiv_o, tsel_o, ser_tail_o, e.m, e.n, e.t, e.tail);
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) scfg_din = b;
    @(negedge clk) scfg_clk = 1'b1;
    sr_model = {sr_model[12:0], b};
    @(negedge clk);
    @(negedge clk);
    @(negedge clk) scfg_clk = 1'b0;
  endtask

  task automatic send_word(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] w;
    w = {t, n, m};
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe(input string tag);
    @(negedge clk) scfg_strobe = 1'b1;
    @(negedge clk);
    if (pcfg_hold) begin
      e_t = sr_model[13:11]; e_n = sr_model[10:9]; e_m = sr_model[8:0];
    end
    scfg_strobe = 1'b0;
    @(negedge clk);
    push(tag);
  endtask

  task automatic par_drive(input logic [8:0] m, input logic [1:0] n, input string tag);
    @(negedge clk) begin pin_mult = m; pin_odiv = n; pcfg_hold = 1'b0; end
    e_m = m; e_n = n; e_t = 3'b000;
    @(negedge clk);
    push(tag);
  endtask

  initial begin
    rst = 1'b1; scfg_clk = 1'b0; scfg_din = 1'b0; scfg_strobe = 1'b0;
    pcfg_hold = 1'b1; pin_mult = 9'h1FF; pin_odiv = 2'b11;
    repeat (3) @(negedge clk);
    push("R1 reset state");
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    push("R4 closed latches after reset");

    // Parallel power-up load
    par_drive(9'h106, 2'b01, "R5 pins followed");
    par_drive(9'h0A5, 2'b10, "R5 second pin value");
    @(negedge clk) begin pcfg_hold = 1'b1; pin_mult = 9'h13C; pin_odiv = 2'b00; end
    @(negedge clk);
    push("R5 capture on hold rise");

    // Serial word without strobe: outputs frozen, tail visible
    send_word(3'b101, 2'b11, 9'h1C3);
    push("R4 no strobe keeps config / R9 tail");
    strobe("R3 field order word A");

    send_word(3'b010, 2'b00, 9'h055);
    push("R4 shifting after strobe fall keeps word A");
    strobe("R3 field order word B");

    // Parallel priority
    par_drive(9'h1FF, 2'b00, "R6 test code forced zero");
    strobe("R7 strobe ignored with hold low");
    push("R9 tail while hold low");
    @(negedge clk) pcfg_hold = 1'b1;
    @(negedge clk);
    push("R5 hold rise keeps pins");

    // Reapply without new bits
    strobe("R8 reapply retained word");

    // Single bit then check tail motion
    send_bit(1'b1);
    push("R2 single shift moves tail");
    send_word(3'b111, 2'b10, 9'h100);
    strobe("R2 R3 held serial clock shifts once");
    send_word(3'b001, 2'b01, 9'h001);
    strobe("R3 low-bit word");

    // Reset again mid-operation
    @(negedge clk) rst = 1'b1;
    sr_model = '0; e_m = '0; e_n = '0; e_t = '0;
    @(negedge clk);
    push("R1 reset clears loaded state");
    @(negedge clk) rst = 1'b0;

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule